// File: doc/BRIEF.md
# Endpoint FIFO MCU Access Controller

This block sits between a small microcontroller and four packet buffers that serve USB endpoints. The microcontroller sees two byte-wide registers: a command/status register and a data port. To move a packet it names a buffer, sets the direction and raises a request. It then polls a ready flag and moves bytes one at a time through the data port. The transfer ends when the microcontroller flips the direction bit while the request is still high. After that it drops the request. That flip commits the packet. A written packet passes to the serial-engine side together with its byte count. A read packet returns its buffer to the serial engine.

The serial-engine side loads bytes into an empty buffer and commits them as a received packet, optionally marked as SETUP data. It reads outgoing packets by byte address and releases them once they are sent. Two sticky flags in the command/status register report a received zero-length packet and received SETUP data. Each flag has its own clearing rule.

Top module: `ep_fifo_access`

## Requirements
- R1: After reset the command/status register reads 0x00, every buffer byte count is 0 and no outgoing packet is pending.
- R2: The command/status register layout, from bit 7 down, is: zero-length flag, ready (read-only), SETUP flag, buffer select (two bits, bit 4 high; value n selects buffer n), clear, direction (1 = microcontroller writes), request. Written select, direction and request bits read back unchanged.
- R3: With request 1 and direction 0, ready reads 1 while the selected buffer holds a received packet with unread bytes. Each data-port read returns the next byte in the order the serial engine loaded them.
- R4: Ready falls once every byte of the packet has been read. The access pointer never exceeds 8.
- R5: With request 1 and direction 1, ready reads 1 while the selected buffer is empty and not being filled by the serial engine. Ready falls after 8 data-port writes.
- R6: Flipping direction from 1 to 0 with request held high commits the written bytes. The buffer's pending bit rises, its count equals the number of bytes written, and the serial engine reads the bytes back in order. A release from the serial engine then clears the pending bit.
- R7: Flipping direction from 0 to 1 with request held high frees the buffer being read, which sets its count to 0 so the serial engine can load it again. Ready stays 0 until request falls and rises again.
- R8: Writing the clear bit as 1 empties the selected buffer whatever the ready state. The clear bit always reads back 0.
- R9: The SETUP flag sets when the serial engine commits a packet marked as SETUP. Writing 0 to it clears it, and writing 1 leaves it unchanged.
- R10: The zero-length flag sets when the serial engine commits a packet with no bytes. A data-port read while that buffer is selected clears it, and so does a SETUP-token pulse from the serial engine. Writes to the command/status register do not touch it.
- R11: Data-port accesses while ready is 0 have no effect. A read returns 0x00 and does not advance the pointer, and a write stores nothing.
- R12: Serial-engine loads into a buffer that holds a packet are ignored, and a buffer's count stops at 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Microcontroller register write strobe |
| reg_rd | input | 1 | Microcontroller register read strobe |
| reg_addr | input | 1 | 0 = command/status register, 1 = data port |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid the cycle after reg_rd |
| sie_load | input | 1 | Serial engine loads one byte into the named buffer |
| sie_fifo | input | 2 | Buffer addressed by the serial-engine strobes |
| sie_wdata | input | 8 | Byte to load |
| sie_commit | input | 1 | Marks the loaded bytes as a received packet |
| sie_setup | input | 1 | The committed packet carries SETUP data |
| sie_setup_tok | input | 1 | A valid SETUP token was accepted |
| sie_rd_addr | input | 3 | Byte address for the serial-engine read |
| sie_rdata | output | 8 | Serial-engine read byte, valid the cycle after the address |
| sie_release | input | 1 | An outgoing packet has been sent, so its buffer is freed |
| sie_tx_pend | output | 4 | One bit per buffer: outgoing packet waiting |
| sie_cnt | output | 16 | Byte count of each buffer, 4 bits per buffer, buffer 0 lowest |

## Verification
A command/status or data-port write takes effect at the clock edge where it is sampled. Any read that starts on the next cycle sees it. A register read returns its value one edge after reg_rd, and a serial-engine read returns one edge after its address. Counts and pending bits move at the edge that samples the strobe. Each bench task holds a strobe from one falling edge to the next and samples outputs on that second falling edge. Every expected value is therefore compared exactly one edge after the stimulus.

// File: rtl/epf_pkg.sv
package epf_pkg;
  typedef enum logic [1:0] {
    SLOT_EMPTY  = 2'd0,
    SLOT_RXFULL = 2'd1,
    SLOT_TXFULL = 2'd2
  } slot_st_e;

  // bit positions inside the command/status byte
  localparam int B_REQ   = 0;
  localparam int B_DIR   = 1;
  localparam int B_CLR   = 2;
  localparam int B_SELLO = 3;
  localparam int B_SETUP = 5;
  localparam int B_RDY   = 6;
  localparam int B_ZLP   = 7;
endpackage

// File: rtl/epf_store.sv
module epf_store #(
  parameter int DW    = 8,
  parameter int WORDS = 32,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_we) mem[b_addr] <= b_wdata;
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/epf_slot.sv
module epf_slot
  import epf_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          sie_load_i,
  input  logic          sie_commit_i,
  input  logic          mcu_wr_commit_i,
  input  logic [CW-1:0] mcu_wr_count_i,
  input  logic          mcu_rd_commit_i,
  input  logic          sie_release_i,
  output slot_st_e      state_o,
  output logic [CW-1:0] count_o
);
  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      state_o <= SLOT_EMPTY;
      count_o <= '0;
    end else begin
      unique case (state_o)
        SLOT_EMPTY: begin
          if (mcu_wr_commit_i) begin
            state_o <= SLOT_TXFULL;
            count_o <= mcu_wr_count_i;
          end else if (sie_commit_i) begin
            state_o <= SLOT_RXFULL;
          end else if (sie_load_i && count_o < CW'(DEPTH)) begin
            count_o <= count_o + 1'b1;
          end
        end
        SLOT_RXFULL: if (mcu_rd_commit_i) begin
          state_o <= SLOT_EMPTY;
          count_o <= '0;
        end
        SLOT_TXFULL: if (sie_release_i) begin
          state_o <= SLOT_EMPTY;
          count_o <= '0;
        end
        default: state_o <= SLOT_EMPTY;
      endcase
    end
  end

  // R12
  cnt_cap_chk: assert property (@(posedge clk) disable iff (rst)
    count_o <= CW'(DEPTH));

  // R6
  wr_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (mcu_wr_commit_i && state_o == SLOT_EMPTY && !clr_i)
    |=> (state_o == SLOT_TXFULL && count_o == $past(mcu_wr_count_i)));

  // R7
  rd_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (mcu_rd_commit_i && state_o == SLOT_RXFULL)
    |=> (state_o == SLOT_EMPTY && count_o == '0));
endmodule

// File: rtl/ep_fifo_access.sv
module ep_fifo_access
  import epf_pkg::*;
#(
  parameter int FIFOS = 4,
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int SW   = $clog2(FIFOS),
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int AW   = SW + PW
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic                reg_addr,
  input  logic [7:0]          reg_wdata,
  output logic [7:0]          reg_rdata,
  input  logic                sie_load,
  input  logic [SW-1:0]       sie_fifo,
  input  logic [DW-1:0]       sie_wdata,
  input  logic                sie_commit,
  input  logic                sie_setup,
  input  logic                sie_setup_tok,
  input  logic [PW-1:0]       sie_rd_addr,
  output logic [DW-1:0]       sie_rdata,
  input  logic                sie_release,
  output logic [FIFOS-1:0]    sie_tx_pend,
  output logic [FIFOS*CW-1:0] sie_cnt
);
  logic          req, dir, done, setup_f, zlp_f;
  logic [SW-1:0] sel, zlp_fifo;
  logic [CW-1:0] ptr;
  slot_st_e      slot_st  [FIFOS];
  logic [CW-1:0] slot_cnt [FIFOS];

  logic ctrl_wr, data_rd_hit, data_rd_ok, data_wr_ok, ready;
  logic commit_any, commit_wr, commit_rd, zlp_set, sie_we;
  logic [7:0] status_now;
  logic [DW-1:0] a_rdata;
  logic [AW-1:0] b_addr;
  logic unused_wbits;

  assign unused_wbits = ^{reg_wdata[B_ZLP], reg_wdata[B_RDY]};

  assign ctrl_wr     = reg_wr && !reg_addr;
  assign data_rd_hit = reg_rd && reg_addr && !reg_wr;
  assign ready = req && !done &&
    (dir ? (slot_st[sel] == SLOT_EMPTY && slot_cnt[sel] == '0 && ptr < CW'(DEPTH))
         : (slot_st[sel] == SLOT_RXFULL && ptr < slot_cnt[sel]));
  assign data_rd_ok = data_rd_hit && ready && !dir;
  assign data_wr_ok = reg_wr && reg_addr && ready && dir;

  // a direction flip with request held high ends the transfer
  assign commit_any = ctrl_wr && req && reg_wdata[B_REQ] && !done &&
                      (reg_wdata[B_DIR] != dir);
  assign commit_wr  = commit_any && dir;
  assign commit_rd  = commit_any && !dir;
  assign zlp_set    = sie_commit && slot_st[sie_fifo] == SLOT_EMPTY &&
                      slot_cnt[sie_fifo] == '0;
  assign sie_we     = sie_load && slot_st[sie_fifo] == SLOT_EMPTY &&
                      slot_cnt[sie_fifo] < CW'(DEPTH);

  assign status_now = {zlp_f, ready, setup_f, sel, 1'b0, dir, req};

  always_ff @(posedge clk) begin
    if (rst) begin
      req <= 1'b0; dir <= 1'b0; done <= 1'b0; sel <= '0; ptr <= '0;
      setup_f <= 1'b0; zlp_f <= 1'b0; zlp_fifo <= '0;
    end else begin
      if (ctrl_wr) begin
        req <= reg_wdata[B_REQ];
        dir <= reg_wdata[B_DIR];
        sel <= reg_wdata[B_SELLO +: SW];
        if (!req && reg_wdata[B_REQ]) begin
          ptr  <= '0;
          done <= 1'b0;
        end
        if (commit_any) done <= 1'b1;
        if (reg_wdata[B_CLR]) ptr <= '0;
        if (!reg_wdata[B_SETUP]) setup_f <= 1'b0;
      end else if (data_rd_ok || data_wr_ok) begin
        ptr <= ptr + 1'b1;
      end
      if (data_rd_hit && sel == zlp_fifo) zlp_f <= 1'b0;
      if (sie_setup_tok) zlp_f <= 1'b0;
      if (zlp_set) begin
        zlp_f    <= 1'b1;
        zlp_fifo <= sie_fifo;
      end
      if (sie_commit && sie_setup) setup_f <= 1'b1;
    end
  end

  // registered read path
  logic       rd_is_data_q, rd_ok_q;
  logic [7:0] status_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_is_data_q <= 1'b0;
      rd_ok_q      <= 1'b0;
      status_q     <= '0;
    end else if (reg_rd) begin
      rd_is_data_q <= reg_addr;
      rd_ok_q      <= data_rd_ok;
      status_q     <= status_now;
    end
  end
  assign reg_rdata = rd_is_data_q ? (rd_ok_q ? a_rdata : '0) : status_q;

  assign b_addr = sie_load ? {sie_fifo, slot_cnt[sie_fifo][PW-1:0]}
                           : {sie_fifo, sie_rd_addr};

  epf_store #(.DW(DW), .WORDS(FIFOS * DEPTH)) u_store (
    .clk    (clk),
    .a_we   (data_wr_ok),
    .a_addr ({sel, ptr[PW-1:0]}),
    .a_wdata(reg_wdata[DW-1:0]),
    .a_rdata(a_rdata),
    .b_we   (sie_we),
    .b_addr (b_addr),
    .b_wdata(sie_wdata),
    .b_rdata(sie_rdata)
  );

  for (genvar i = 0; i < FIFOS; i++) begin : g_slot
    logic hit_sie, hit_mcu;
    assign hit_sie = (sie_fifo == SW'(i));
    assign hit_mcu = (sel == SW'(i));
    epf_slot #(.DEPTH(DEPTH)) u_slot (
      .clk            (clk),
      .rst            (rst),
      .clr_i          (ctrl_wr && reg_wdata[B_CLR] && reg_wdata[B_SELLO +: SW] == SW'(i)),
      .sie_load_i     (sie_load && hit_sie),
      .sie_commit_i   (sie_commit && hit_sie),
      .mcu_wr_commit_i(commit_wr && hit_mcu),
      .mcu_wr_count_i (ptr),
      .mcu_rd_commit_i(commit_rd && hit_mcu),
      .sie_release_i  (sie_release && hit_sie),
      .state_o        (slot_st[i]),
      .count_o        (slot_cnt[i])
    );
    assign sie_tx_pend[i]        = (slot_st[i] == SLOT_TXFULL);
    assign sie_cnt[i*CW +: CW]   = slot_cnt[i];
  end

  // R4
  ptr_bound_chk: assert property (@(posedge clk) disable iff (rst)
    ptr <= CW'(DEPTH));

  // R11
  ignored_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (data_rd_hit && !ready) |=> $stable(ptr));

  // R9
  setup_set_chk: assert property (@(posedge clk) disable iff (rst)
    (sie_commit && sie_setup) |=> setup_f);

  // R10
  zlp_tok_chk: assert property (@(posedge clk) disable iff (rst)
    (sie_setup_tok && !zlp_set) |=> !zlp_f);
endmodule

// File: tb/ep_fifo_access_bench.sv
module ep_fifo_access_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0, reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic sie_load = 0, sie_commit = 0, sie_setup = 0, sie_setup_tok = 0, sie_release = 0;
  logic [1:0] sie_fifo = 0;
  logic [7:0] sie_wdata = 0, sie_rdata;
  logic [2:0] sie_rd_addr = 0;
  logic [3:0] sie_tx_pend;
  logic [15:0] sie_cnt;
  int checks = 0, failures = 0;
  logic [7:0] got;

  always #10 clk = ~clk;

  ep_fifo_access u_ep_fifo_access (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sie_load(sie_load),
    .sie_fifo(sie_fifo), .sie_wdata(sie_wdata), .sie_commit(sie_commit),
    .sie_setup(sie_setup), .sie_setup_tok(sie_setup_tok), .sie_rd_addr(sie_rd_addr),
    .sie_rdata(sie_rdata), .sie_release(sie_release), .sie_tx_pend(sie_tx_pend),
    .sie_cnt(sie_cnt)
  );

  task automatic check(input string rq, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic reg_write(input logic a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic reg_read(input logic a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic load(input logic [1:0] f, input logic [7:0] d);
    @(negedge clk); sie_load = 1; sie_fifo = f; sie_wdata = d;
    @(negedge clk); sie_load = 0;
  endtask

  task automatic commit(input logic [1:0] f, input logic setup);
    @(negedge clk); sie_commit = 1; sie_fifo = f; sie_setup = setup;
    @(negedge clk); sie_commit = 0; sie_setup = 0;
  endtask

  task automatic sie_get(input logic [1:0] f, input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); sie_fifo = f; sie_rd_addr = a;
    @(negedge clk); d = sie_rdata;
  endtask

  task automatic release_buf(input logic [1:0] f);
    @(negedge clk); sie_release = 1; sie_fifo = f;
    @(negedge clk); sie_release = 0;
  endtask

  // {rd, addr, wdata, expected, requirement}
  localparam logic [21:0] VECS [0:11] = '{
    {1'b0, 1'b0, 8'h09, 8'h00, 4'd3},  // R3 select buffer 1, read, request
    {1'b1, 1'b0, 8'h00, 8'h49, 4'd3},  // R3 ready up
    {1'b1, 1'b1, 8'h00, 8'hA1, 4'd3},  // R3 bytes in load order
    {1'b1, 1'b1, 8'h00, 8'hB2, 4'd3},
    {1'b1, 1'b1, 8'h00, 8'hC3, 4'd3},
    {1'b1, 1'b0, 8'h00, 8'h09, 4'd4},  // R4 ready down after last byte
    {1'b1, 1'b1, 8'h00, 8'h00, 4'd11}, // R11 ignored read
    {1'b0, 1'b0, 8'h0B, 8'h00, 4'd7},  // R7 direction flip commits
    {1'b1, 1'b0, 8'h00, 8'h0B, 4'd7},  // R7 ready held low
    {1'b0, 1'b0, 8'h0A, 8'h00, 4'd2},
    {1'b1, 1'b0, 8'h00, 8'h0A, 4'd2},  // R2 readback
    {1'b0, 1'b0, 8'h00, 8'h00, 4'd2}
  };

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    reg_read(0, got); check("R1", got, 8'h00);
    check("R1", sie_cnt, 16'h0000);
    check("R1", sie_tx_pend, 4'h0);

    load(1, 8'hA1); load(1, 8'hB2); load(1, 8'hC3); commit(1, 0);
    for (int i = 0; i < 12; i++) begin
      if (VECS[i][21]) begin
        reg_read(VECS[i][20], got);
        check($sformatf("R%0d", VECS[i][3:0]), got, VECS[i][11:4]);
      end else begin
        reg_write(VECS[i][20], VECS[i][19:12]);
      end
    end
    check("R7 freed", sie_cnt[7:4], 4'd0);
    load(1, 8'h5A);
    check("R7 reload", sie_cnt[7:4], 4'd1);
    reg_write(0, 8'h0C); reg_write(0, 8'h00);

    // R5 / R6 full write to buffer 2
    reg_write(0, 8'h13);
    reg_read(0, got); check("R5", got, 8'h53);
    for (int i = 0; i < 8; i++) reg_write(1, 8'h10 + 8'(i));
    reg_read(0, got); check("R5", got, 8'h13);
    reg_write(1, 8'hEE); // R11 ignored write
    reg_write(0, 8'h11);
    check("R6", sie_tx_pend, 4'b0100);
    check("R11", sie_cnt[11:8], 4'd8);
    sie_get(2, 3, got); check("R6", got, 8'h13);
    sie_get(2, 7, got); check("R11", got, 8'h17);
    reg_write(0, 8'h10);
    release_buf(2);
    check("R6", sie_tx_pend, 4'b0000);

    // R6 short write to buffer 0
    reg_write(0, 8'h03);
    reg_write(1, 8'h77); reg_write(1, 8'h66);
    reg_write(0, 8'h01);
    check("R6", sie_cnt[3:0], 4'd2);
    sie_get(0, 1, got); check("R6", got, 8'h66);
    reg_write(0, 8'h00);
    release_buf(0);

    // R8 clear
    for (int i = 0; i < 4; i++) load(3, 8'(i));
    commit(3, 0);
    check("R8", sie_cnt[15:12], 4'd4);
    reg_write(0, 8'h1C);
    reg_read(0, got); check("R8", got, 8'h18);
    check("R8", sie_cnt[15:12], 4'd0);
    reg_write(0, 8'h19);
    reg_read(0, got); check("R8", got, 8'h19);
    reg_write(0, 8'h18);

    // R9 SETUP flag
    load(0, 8'h80); load(0, 8'h06); commit(0, 1);
    reg_read(0, got); check("R9", got, 8'h38);
    reg_write(0, 8'h18);
    reg_read(0, got); check("R9", got, 8'h18);
    reg_write(0, 8'h38);
    reg_read(0, got); check("R9", got, 8'h18);
    reg_write(0, 8'h04); reg_write(0, 8'h00);

    // R10 zero-length flag
    reg_write(0, 8'h08);
    commit(1, 0);
    reg_read(0, got); check("R10", got, 8'h88);
    reg_write(0, 8'h09);
    reg_read(0, got); check("R10", got, 8'h89);
    reg_read(1, got); check("R11", got, 8'h00);
    reg_read(0, got); check("R10", got, 8'h09);
    commit(2, 0);
    reg_read(0, got); check("R10", got, 8'h89);
    @(negedge clk); sie_setup_tok = 1;
    @(negedge clk); sie_setup_tok = 0;
    reg_read(0, got); check("R10", got, 8'h09);

    // R12 loads ignored on full buffer, count capped
    load(1, 8'h44);
    check("R12", sie_cnt[7:4], 4'd0);
    for (int i = 0; i < 9; i++) load(0, 8'(i));
    check("R12", sie_cnt[3:0], 4'd8);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule